// File: doc/BRIEF.md
# Sectioned GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O peripheral for 32 pads. The pads are grouped into four identical groups of eight. Each group has its own 64-byte register window for pad direction, output data, sampled input, trigger type, interrupt status and interrupt mask. Pin `n` belongs to group `n>>3` and uses bit `n&7` in every register of that group.

Pad inputs are resampled through a two-stage synchroniser. They are then watched for interrupt events. A pin set to edge mode records a rising edge of its synchronised input. A pin set to level mode records an event on every cycle its synchronised input is high. Software clears status bits by writing ones. Mask bits are set and cleared through two separate write-one addresses, so no read-modify-write is needed. The single interrupt line is high when any status bit in any group is pending and not masked.

The register bus is a plain synchronous port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from the current address.

Top module: `sect_gpio`

## Requirements
- R1: After reset, every group reads mask 0xFF, direction 0xFF, output data 0x00, trigger type 0x00 and status 0x00. `irq` is low and every `pad_oe` bit is low.
- R2: Group `g` occupies byte addresses `0x40*g` to `0x40*g+0x3F`. Pin `n` is bit `n&7` of group `n>>3`, on the pads and in every register.
- R3: Offset 0x10 is the read/write direction register, where 1 means input. Offset 0x14 is the read/write output data register. `pad_oe[n]` is the inverse of pin n's direction bit, and `pad_out[n]` is its output data bit. Both pad ports change on the clock edge of the write.
- R4: Offset 0x18 is read-only. It returns the pad inputs after two clock edges of synchronisation. Writes to it have no effect.
- R5: In edge mode (trigger bit 0), a pin's status bit is set by a 0-to-1 change of its synchronised input. An input that stays high does not set it again after it has been cleared.
- R6: Offset 0x20 is the read/write trigger type, where 1 means level mode. In level mode, the status bit is set on every cycle the synchronised input is high.
- R7: Offset 0x04 reads the raw status. Writing it clears each status bit whose write-data bit is 1 and leaves the others. If a clear and a new event reach the same bit in the same cycle, the bit ends up set.
- R8: Writing ones to offset 0x0C sets those mask bits, and this offset reads the mask. Writing ones to offset 0x08 clears those mask bits, and this offset reads 0. Zero data bits leave the mask unchanged at both offsets.
- R9: Offset 0x00 is read-only. It returns raw status AND NOT mask. Writes to it have no effect.
- R10: `irq` is high in a cycle exactly when some group has a status bit set whose mask bit is clear.
- R11: Offsets other than the eight above read 0 and ignore writes. Bits 31:8 of every read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enables, 1 drives the pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four groups of eight pins, an 8-bit address and a two-stage synchroniser. This makes the whole address space reachable. Random traffic therefore covers every group, the unmapped holes and the group-select bits. Because the synchroniser is two stages deep, the bench can line up a rising input with a clear write in the same cycle. A bench cycle model predicts, every cycle, the read data, the pad outputs and the interrupt line. Directed sequences pin down the edge/level difference, clear-versus-event priority and the mask-set and mask-clear addresses.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

   // each group owns a 64-byte window
   localparam int SECT_AW = 6;

   // register offsets inside a group window
   localparam logic [SECT_AW-1:0] OFF_PEND   = 6'h00;
   localparam logic [SECT_AW-1:0] OFF_RAW    = 6'h04;
   localparam logic [SECT_AW-1:0] OFF_UNMASK = 6'h08;
   localparam logic [SECT_AW-1:0] OFF_MASK   = 6'h0C;
   localparam logic [SECT_AW-1:0] OFF_DIR    = 6'h10;
   localparam logic [SECT_AW-1:0] OFF_DOUT   = 6'h14;
   localparam logic [SECT_AW-1:0] OFF_DIN    = 6'h18;
   localparam logic [SECT_AW-1:0] OFF_TRIG   = 6'h20;

   // one-hot register select
   typedef struct packed {
      logic pend;
      logic raw;
      logic unmask;
      logic mask;
      logic dir;
      logic dout;
      logic din;
      logic trig;
   } reg_sel_t;

   function automatic reg_sel_t decode_off(input logic [SECT_AW-1:0] off);
      reg_sel_t s;
      s = '0;
      case (off)
         OFF_PEND:   s.pend   = 1'b1;
         OFF_RAW:    s.raw    = 1'b1;
         OFF_UNMASK: s.unmask = 1'b1;
         OFF_MASK:   s.mask   = 1'b1;
         OFF_DIR:    s.dir    = 1'b1;
         OFF_DOUT:   s.dout   = 1'b1;
         OFF_DIN:    s.din    = 1'b1;
         OFF_TRIG:   s.trig   = 1'b1;
         default:    s        = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sgpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sgpio_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sgpio_section.sv
module sgpio_section
   import sgpio_pkg::*;
#(
   parameter int SW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SECT_AW-1:0] off,
   input  logic [SW-1:0]      wdata,
   input  logic [SW-1:0]      din,
   output logic [SW-1:0]      rdata,
   output logic [SW-1:0]      dout,
   output logic [SW-1:0]      dir,
   output logic               irq_any
);

   reg_sel_t     sel;
   logic [SW-1:0] trig_q, mask_q, stat_q, prev_q;
   logic [SW-1:0] evt, clr, stat_nxt;

   assign sel = decode_off(off);

   // event detection: level pins follow input, edge pins see 0->1
   assign evt      = (trig_q & din) | (~trig_q & din & ~prev_q);
   assign clr      = (wr_en && sel.raw) ? wdata : '0;
   assign stat_nxt = (stat_q & ~clr) | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir    <= '1;
         dout   <= '0;
         trig_q <= '0;
         mask_q <= '1;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= din;
         stat_q <= stat_nxt;
         if (wr_en) begin
            if (sel.dir)    dir    <= wdata;
            if (sel.dout)   dout   <= wdata;
            if (sel.trig)   trig_q <= wdata;
            if (sel.mask)   mask_q <= mask_q | wdata;
            if (sel.unmask) mask_q <= mask_q & ~wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel.pend) rdata = stat_q & ~mask_q;
      if (sel.raw)  rdata = stat_q;
      if (sel.mask) rdata = mask_q;
      if (sel.dir)  rdata = dir;
      if (sel.dout) rdata = dout;
      if (sel.din)  rdata = din;
      if (sel.trig) rdata = trig_q;
   end

   assign irq_any = |(stat_q & ~mask_q);

endmodule

// File: rtl/sect_gpio.sv
module sect_gpio
   import sgpio_pkg::*;
#(
   parameter int NUM_SECT    = 4,
   parameter int SECT_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_SECT*SECT_W-1:0] pad_in,
   output logic [NUM_SECT*SECT_W-1:0] pad_out,
   output logic [NUM_SECT*SECT_W-1:0] pad_oe,
   output logic                       irq
);

   localparam int NPIN   = NUM_SECT * SECT_W;
   localparam int SIDX_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
   localparam int HI_W   = ADDR_W - SECT_AW - SIDX_W;

   if (NUM_SECT < 2) begin : g_bad_sect
      $error("sect_gpio: NUM_SECT must be at least 2");
   end
   if (SECT_W < 1 || SECT_W >= DATA_W) begin : g_bad_sw
      $error("sect_gpio: SECT_W must be between 1 and DATA_W-1");
   end
   if (SECT_W > 32) begin : g_bad_sw_win
      $error("sect_gpio: SECT_W must fit a 32-bit register");
   end
   if (HI_W < 0) begin : g_bad_addr
      $error("sect_gpio: ADDR_W too narrow for the group windows");
   end

   logic [SIDX_W-1:0] sidx;
   logic [SECT_AW-1:0] off;
   logic               hi_ok;
   logic [NPIN-1:0]    din_sync;
   logic [SECT_W-1:0]  rd_s  [NUM_SECT];
   logic [NUM_SECT-1:0] irq_s;
   logic               unused_wdata;

   assign sidx = bus_addr[SECT_AW +: SIDX_W];
   assign off  = bus_addr[SECT_AW-1:0];
   assign unused_wdata = ^bus_wdata[DATA_W-1:SECT_W];

   // address bits above the group index must be zero for a hit
   if (HI_W > 0) begin : g_hi_chk
      assign hi_ok = (bus_addr[ADDR_W-1 -: HI_W] == '0);
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end

   sgpio_sync #(
      .W      (NPIN),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (din_sync)
   );

   for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      logic [SECT_W-1:0] dir_s;
      logic              hit;

      assign hit = hi_ok && (sidx == SIDX_W'(s));

      sgpio_section #(
         .SW (SECT_W)
      ) u_sec (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_we && hit),
         .off     (off),
         .wdata   (bus_wdata[SECT_W-1:0]),
         .din     (din_sync[s*SECT_W +: SECT_W]),
         .rdata   (rd_s[s]),
         .dout    (pad_out[s*SECT_W +: SECT_W]),
         .dir     (dir_s),
         .irq_any (irq_s[s])
      );

      assign pad_oe[s*SECT_W +: SECT_W] = ~dir_s;
   end

   always_comb begin
      bus_rdata = '0;
      for (int s = 0; s < NUM_SECT; s++) begin
         if (hi_ok && (sidx == SIDX_W'(s))) bus_rdata[SECT_W-1:0] = rd_s[s];
      end
   end

   assign irq = |irq_s;

endmodule

// File: rtl/sgpio_chk.sv
module sgpio_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SW     = 8,
   parameter int NPIN   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPIN-1:0]   pad_out,
   input logic [NPIN-1:0]   pad_oe,
   input logic              irq
);

   // R3: a direction write to group 0 shows on the enables next cycle
   a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'('h10))
      |=> (pad_oe[SW-1:0] == ~$past(bus_wdata[SW-1:0])));

   // R3: an output-data write to group 0 shows on the pads next cycle
   a_r3_dout_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'('h14))
      |=> (pad_out[SW-1:0] == $past(bus_wdata[SW-1:0])));

   // R8: the mask-clear address always reads zero
   a_r8_unmask_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[5:0] == 6'h08) |-> (bus_rdata == '0));

   // R11: only the low register bits carry data
   a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata >> SW) == '0));

   // R10: any pending unmasked status seen on the bus implies irq
   a_r10_pend_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[5:0] == 6'h00 && bus_rdata != '0) |-> irq);

endmodule

bind sect_gpio sgpio_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .SW     (SECT_W),
   .NPIN   (NUM_SECT*SECT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq)
);

// File: tb/test_sect_gpio.sv
`timescale 1ns/1ps
module test_sect_gpio;

   localparam real CLK_P = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int errors = 0;
   int checks = 0;
   logic [31:0] pad_v = '0;

   // bench model
   logic [7:0]  m_mask [4];
   logic [7:0]  m_dir  [4];
   logic [7:0]  m_out  [4];
   logic [7:0]  m_trig [4];
   logic [7:0]  m_st   [4];
   logic [31:0] s1, s2, pv;

   always #(CLK_P/2) clk = ~clk;

   sect_gpio i_sect_gpio (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic void model_reset();
      for (int g = 0; g < 4; g++) begin
         m_mask[g] = 8'hFF; m_dir[g] = 8'hFF; m_out[g] = '0;
         m_trig[g] = '0;    m_st[g]  = '0;
      end
      s1 = '0; s2 = '0; pv = '0;
   endfunction

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      int g = int'(a[7:6]);
      logic [7:0] v;
      case (a[5:0])
         6'h00:   v = m_st[g] & ~m_mask[g];
         6'h04:   v = m_st[g];
         6'h0C:   v = m_mask[g];
         6'h10:   v = m_dir[g];
         6'h14:   v = m_out[g];
         6'h18:   v = s2[g*8 +: 8];
         6'h20:   v = m_trig[g];
         default: v = 8'h00;
      endcase
      return {24'h0, v};
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a[5:0])
         6'h00:          return "R9";
         6'h04:          return "R7";
         6'h08, 6'h0C:   return "R8";
         6'h10, 6'h14:   return "R3";
         6'h18:          return "R4";
         6'h20:          return "R6";
         default:        return "R11";
      endcase
   endfunction

   function automatic logic model_irq();
      logic r = 1'b0;
      for (int g = 0; g < 4; g++) r |= |(m_st[g] & ~m_mask[g]);
      return r;
   endfunction

   function automatic void model_step(input bit we, input logic [7:0] a, input logic [31:0] wd);
      int sg = int'(a[7:6]);
      for (int g = 0; g < 4; g++) begin
         logic [7:0] d  = s2[g*8 +: 8];
         logic [7:0] p  = pv[g*8 +: 8];
         logic [7:0] ev = (m_trig[g] & d) | (~m_trig[g] & d & ~p);
         logic [7:0] cl = (we && g == sg && a[5:0] == 6'h04) ? wd[7:0] : 8'h00;
         m_st[g] = (m_st[g] & ~cl) | ev;
      end
      if (we) begin
         case (a[5:0])
            6'h08: m_mask[sg] = m_mask[sg] & ~wd[7:0];
            6'h0C: m_mask[sg] = m_mask[sg] | wd[7:0];
            6'h10: m_dir[sg]  = wd[7:0];
            6'h14: m_out[sg]  = wd[7:0];
            6'h20: m_trig[sg] = wd[7:0];
            default: ;
         endcase
      end
      pv = s2; s2 = s1; s1 = pad_v;
   endfunction

   // one bus cycle with full comparison against the model
   task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      input string tag, input int expv);
      string t;
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = wd; pad_in = pad_v;
      #0.5;
      t = (tag == "") ? tag_of(a) : tag;
      check(bus_rdata, model_rd(a), t);
      if (expv >= 0) check(bus_rdata, 32'(expv), t);
      check({31'h0, irq}, {31'h0, model_irq()}, "R10");
      check(pad_out, {m_out[3], m_out[2], m_out[1], m_out[0]}, "R3");
      check(pad_oe, ~{m_dir[3], m_dir[2], m_dir[1], m_dir[0]}, "R3");
      model_step(we, a, wd);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values in every group
      for (int g = 0; g < 4; g++) begin
         logic [7:0] b = 8'(g * 64);
         cyc(0, b | 8'h0C, 0, "R1", 'hFF);
         cyc(0, b | 8'h10, 0, "R1", 'hFF);
         cyc(0, b | 8'h14, 0, "R1", 0);
         cyc(0, b | 8'h20, 0, "R1", 0);
         cyc(0, b | 8'h04, 0, "R1", 0);
      end
      check(pad_oe, 32'h0, "R1");
      check({31'h0, irq}, 32'h0, "R1");

      // R2: pin 20 is group 2 bit 4
      cyc(1, 8'h94, 32'h10, "R2", -1);
      cyc(1, 8'h90, 32'hEF, "R2", -1);
      cyc(0, 8'h90, 0, "R2", 'hEF);
      check({31'h0, pad_out[20]}, 32'h1, "R2");
      check({31'h0, pad_oe[20]},  32'h1, "R2");
      check(pad_oe & ~32'h0010_0000, 32'h0, "R2");

      // R4: two-edge synchroniser latency on pin 3
      pad_v[3] = 1'b1;
      cyc(0, 8'h18, 0, "R4", 0);
      cyc(0, 8'h18, 0, "R4", 0);
      cyc(0, 8'h18, 0, "R4", 'h08);
      // R8: clear mask bit 3, read of clear address is zero
      cyc(1, 8'h08, 32'h08, "R8", 0);
      cyc(0, 8'h00, 0, "R9", 'h08);
      check({31'h0, irq}, 32'h1, "R10");
      // R5: clear while input held high stays clear in edge mode
      cyc(1, 8'h04, 32'h08, "R7", 'h08);
      cyc(0, 8'h04, 0, "R5", 0);
      cyc(0, 8'h04, 0, "R5", 0);
      // R8: set mask bit 3 again
      cyc(1, 8'h0C, 32'h08, "R8", 'hF7);
      cyc(0, 8'h0C, 0, "R8", 'hFF);
      // R8: zero data bits leave mask alone
      cyc(1, 8'h08, 32'h00, "R8", -1);
      cyc(0, 8'h0C, 0, "R8", 'hFF);
      // R6: level mode refires while high
      cyc(1, 8'h20, 32'h08, "R6", -1);
      cyc(0, 8'h04, 0, "R6", 0);
      cyc(0, 8'h04, 0, "R6", 'h08);
      cyc(1, 8'h04, 32'h08, "R7", 'h08);
      cyc(0, 8'h04, 0, "R6", 'h08);

      // R7: edge event on pin 24 coincides with a clear
      pad_v[24] = 1'b1;
      cyc(0, 8'hD8, 0, "R7", 0);
      cyc(0, 8'hC4, 0, "R7", 0);
      cyc(1, 8'hC4, 32'h01, "R7", 0);
      cyc(0, 8'hC4, 0, "R7", 'h01);

      // R9 / R4 / R11: writes to read-only and unmapped offsets
      cyc(1, 8'hC0, 32'hFF, "R9", -1);
      cyc(0, 8'hC0, 0, "R9", 0);
      cyc(1, 8'h18, 32'hFFFF_FFFF, "R4", -1);
      cyc(0, 8'h18, 0, "R4", 'h08);
      cyc(1, 8'h5C, 32'hFF, "R11", -1);
      cyc(0, 8'h5C, 0, "R11", 0);
      cyc(0, 8'h7C, 0, "R11", 0);
      cyc(1, 8'h14, 32'hFFFF_FF5A, "R11", -1);
      cyc(0, 8'h14, 0, "R11", 'h5A);

      // random traffic over every group and offset
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  a;
         logic [5:0]  o;
         logic [31:0] wd;
         bit          we;
         case ($urandom % 12)
            0: o = 6'h00;  1: o = 6'h04;  2: o = 6'h08;  3: o = 6'h0C;
            4: o = 6'h10;  5: o = 6'h14;  6: o = 6'h18;  7: o = 6'h20;
            8: o = 6'h1C;  9: o = 6'h24;  10: o = 6'h3C;
            default: o = 6'h04;
         endcase
         a  = {2'($urandom % 4), o};
         wd = $urandom;
         we = ($urandom % 2) == 1;
         pad_v = pad_v ^ ($urandom & $urandom & $urandom);
         cyc(we, a, wd, "", -1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule